// File: doc/BRIEF.md
# Escaped Byte-Stream Command and Memory-Write Decoder

This block sits behind a serial byte link and sorts the incoming bytes into two kinds of traffic. Control traffic is in-band: a reserved escape value (0xA5) followed by a command code switches one of five control levels on or off. All other bytes are packet payload. A doubled escape stands for one payload byte of value 0xA5.

Payload bytes form write packets. Each packet starts with three little-endian 16-bit words: a target word carrying a board number and a DAC channel, a first address, and a last address (inclusive). One 16-bit little-endian data word follows for each address in that range. Every word that is addressed to this board and to an existing channel produces a single-cycle write strobe on the memory port. Words addressed to another board are still consumed, but they cause no write.

Top module: `esc_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until traffic arrives, `cmd_level` is 0 and `wr_en` is 0.
- R2: After an escape byte 0xA5, a byte in the range 0x00..0x09 is a command. Bits [3:1] hold the index: 0 reset, 1 trigger, 2 arm, 3 clock manager, 4 start. Bit 0 clear means enable (the level goes to 1) and bit 0 set means disable (the level goes to 0). `cmd_level[index]` shows the new value in the cycle after the command byte is sampled.
- R3: Each level keeps its value until the same command arrives with the opposite polarity. Commands for other indices, payload bytes and idle cycles leave it unchanged.
- R4: A reset command (0x00 or 0x01) clears all five levels. It then sets `cmd_level[0]` to 1 for 0x00 or to 0 for 0x01, and returns the packet parser to expecting the first header byte.
- R5: The header is six payload bytes, low byte first: the target word, the start address and the end address. The board field is target bits [7:4]. The DAC field is target bits [3:0], and only the values 0..2 are valid.
- R6: Data words arrive low byte first. In the cycle after the high byte is sampled, a matching word gives `wr_en`=1 for exactly one cycle, with `wr_addr` = start + k for the k-th word, `wr_data` = the word, and `wr_dac` = the DAC field. The payload byte that follows the word at the end address is the first byte of a new header.
- R7: The pair 0xA5 0xA5 delivers one payload byte of value 0xA5.
- R8: A packet whose board field differs from `board_id`, or whose DAC field is greater than 2, is parsed to its end and produces no `wr_en`.
- R9: If an escape is followed by a byte that is neither 0xA5 nor in 0x00..0x09, both bytes are dropped, `cmd_level` is unchanged, and the parser restarts at the first header byte.
- R10: A command other than reset that arrives inside a packet does not disturb the packet, and the packet's writes continue normally.
- R11: A cycle with `rx_valid` low has no effect, and `wr_en` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | `rx_byte` holds a byte this cycle |
| rx_byte | input | 8 | Incoming stream byte |
| board_id | input | 4 | Static board number of this unit |
| cmd_level | output | 5 | Command levels: [0] reset, [1] trigger, [2] arm, [3] clock manager, [4] start |
| wr_en | output | 1 | Memory write strobe, one cycle per accepted word |
| wr_dac | output | 2 | Target DAC channel of the write |
| wr_addr | output | 16 | Word address of the write |
| wr_data | output | 16 | Data word of the write |

## Verification
Every result of this block is due exactly one clock after the byte that causes it is sampled. That byte is the command byte for a level change and the high data byte for a write strobe. The escape byte and the header bytes cause no visible change. The bench holds a behavioural model that it advances when it drives each input. It then compares every output on the following falling edge, so each comparison falls one edge after its cause and half a period away from the next edge. Address, data and channel are compared only in cycles where a strobe is expected.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam logic [7:0] ESC_BYTE = 8'hA5;
  localparam int NUM_CMDS = 5;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_TRIGGER = 3'd1,
    CMD_ARM     = 3'd2,
    CMD_CLKMGR  = 3'd3,
    CMD_START   = 3'd4
  } cmd_idx_e;
endpackage

// File: rtl/esc_unescape.sv
module esc_unescape
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic [7:0] byte_out,
  output logic       cmd_valid,
  output logic [3:0] cmd_code,
  output logic       resync
);
  localparam logic [7:0] CMD_LIMIT = 8'(NUM_CMDS * 2);

  logic esc_q, esc_d;

  always_comb begin
    esc_d      = esc_q;
    byte_valid = 1'b0;
    byte_out   = rx_byte;
    cmd_valid  = 1'b0;
    cmd_code   = rx_byte[3:0];
    resync     = 1'b0;
    if (rx_valid) begin
      if (esc_q) begin
        esc_d = 1'b0;
        if (rx_byte == ESC_BYTE)       byte_valid = 1'b1;
        else if (rx_byte < CMD_LIMIT)  cmd_valid  = 1'b1;
        else                           resync     = 1'b1;
      end else if (rx_byte == ESC_BYTE) begin
        esc_d = 1'b1;
      end else begin
        byte_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esc_q <= 1'b0;
    else        esc_q <= esc_d;
  end
endmodule

// File: rtl/esc_cmd_regs.sv
module esc_cmd_regs
  import esc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [3:0]          cmd_code,
  output logic [NUM_CMDS-1:0] cmd_level
);
  logic [NUM_CMDS-1:0] lvl_q, lvl_d;
  cmd_idx_e idx;

  assign idx = cmd_idx_e'(cmd_code[3:1]);

  always_comb begin
    lvl_d = lvl_q;
    if (cmd_valid) begin
      if (idx == CMD_RESET) lvl_d = '0;
      lvl_d[idx] = ~cmd_code[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lvl_q <= '0;
    else if (cmd_valid) lvl_q <= lvl_d;
  end

  assign cmd_level = lvl_q;

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cmd_level));
  // R4
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[3:1] == 3'd0) |=> (cmd_level[NUM_CMDS-1:1] == '0));
  // R2
  enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_code[0]) |=> cmd_level[$past(cmd_code[3:1])]);
endmodule

// File: rtl/esc_pkt_parser.sv
module esc_pkt_parser
  import esc_pkg::*;
#(
  parameter int BOARD_W  = 4,
  parameter int NUM_DACS = 3,
  localparam int DAC_OUT_W = $clog2(NUM_DACS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 byte_valid,
  input  logic [7:0]           byte_in,
  input  logic [BOARD_W-1:0]   board_id,
  output logic                 wr_en,
  output logic [DAC_OUT_W-1:0] wr_dac,
  output logic [WORD_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data
);
  localparam logic [3:0] DAC_LIMIT = 4'(NUM_DACS);

  logic              in_data_q, in_data_d;
  logic [1:0]        hdr_idx_q, hdr_idx_d;
  logic              hi_q, hi_d;
  logic [7:0]        lo_q, lo_d;
  logic [WORD_W-1:0] tgt_q, tgt_d, addr_q, addr_d, end_q, end_d;
  logic              wen_d;
  logic [WORD_W-1:0] waddr_q, waddr_d, wdata_q, wdata_d;
  logic [DAC_OUT_W-1:0] wdac_q, wdac_d;
  logic              wen_q;
  logic [WORD_W-1:0] word;
  logic              target_ok;

  assign word      = {byte_in, lo_q};
  assign target_ok = (tgt_q[4 +: BOARD_W] == board_id) && (tgt_q[3:0] < DAC_LIMIT);

  always_comb begin
    in_data_d = in_data_q;
    hdr_idx_d = hdr_idx_q;
    hi_d      = hi_q;
    lo_d      = lo_q;
    tgt_d     = tgt_q;
    addr_d    = addr_q;
    end_d     = end_q;
    wen_d     = 1'b0;
    waddr_d   = waddr_q;
    wdata_d   = wdata_q;
    wdac_d    = wdac_q;
    if (clear) begin
      in_data_d = 1'b0;
      hdr_idx_d = 2'd0;
      hi_d      = 1'b0;
    end else if (byte_valid) begin
      if (!hi_q) begin
        lo_d = byte_in;
        hi_d = 1'b1;
      end else begin
        hi_d = 1'b0;
        if (!in_data_q) begin
          case (hdr_idx_q)
            2'd0:    tgt_d  = word;
            2'd1:    addr_d = word;
            default: begin
              end_d     = word;
              in_data_d = 1'b1;
            end
          endcase
          hdr_idx_d = (hdr_idx_q == 2'd2) ? 2'd0 : hdr_idx_q + 2'd1;
        end else begin
          wen_d   = target_ok;
          waddr_d = addr_q;
          wdata_d = word;
          wdac_d  = tgt_q[DAC_OUT_W-1:0];
          addr_d  = addr_q + 1'b1;
          if (addr_q == end_q) in_data_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data_q <= 1'b0;
      hdr_idx_q <= 2'd0;
      hi_q      <= 1'b0;
      lo_q      <= '0;
      tgt_q     <= '0;
      addr_q    <= '0;
      end_q     <= '0;
      wen_q     <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      wdac_q    <= '0;
    end else begin
      in_data_q <= in_data_d;
      hdr_idx_q <= hdr_idx_d;
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      tgt_q     <= tgt_d;
      addr_q    <= addr_d;
      end_q     <= end_d;
      wen_q     <= wen_d;
      waddr_q   <= waddr_d;
      wdata_q   <= wdata_d;
      wdac_q    <= wdac_d;
    end
  end

  assign wr_en   = wen_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign wr_dac  = wdac_q;

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !wr_en);
endmodule

// File: rtl/esc_cmd_decoder.sv
module esc_cmd_decoder
  import esc_pkg::*;
#(
  parameter int BOARD_W  = 4,
  parameter int NUM_DACS = 3,
  localparam int DAC_OUT_W = $clog2(NUM_DACS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic [BOARD_W-1:0]   board_id,
  output logic [NUM_CMDS-1:0]  cmd_level,
  output logic                 wr_en,
  output logic [DAC_OUT_W-1:0] wr_dac,
  output logic [WORD_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data
);
  logic       byte_valid, cmd_valid, resync, parser_clear;
  logic [7:0] byte_val;
  logic [3:0] cmd_code;

  esc_unescape u_unesc (
    .clk, .rst_n, .rx_valid, .rx_byte,
    .byte_valid, .byte_out(byte_val), .cmd_valid, .cmd_code, .resync
  );

  esc_cmd_regs u_cmds (
    .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_level
  );

  assign parser_clear = resync || (cmd_valid && cmd_code[3:1] == 3'd0);

  esc_pkt_parser #(.BOARD_W(BOARD_W), .NUM_DACS(NUM_DACS)) u_parse (
    .clk, .rst_n, .clear(parser_clear), .byte_valid, .byte_in(byte_val),
    .board_id, .wr_en, .wr_dac, .wr_addr, .wr_data
  );
endmodule

// File: tb/sim_esc_cmd_decoder.sv
`timescale 1ns/1ps
module sim_esc_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic [3:0]  board_id;
  logic [4:0]  cmd_level;
  logic        wr_en;
  logic [1:0]  wr_dac;
  logic [15:0] wr_addr, wr_data;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  bit          m_esc = 0;
  logic [4:0]  m_lvl = '0;
  byte unsigned m_q[$];
  bit          m_in_data = 0;
  int          m_tgt, m_addr, m_end;
  bit          e_wen;
  int          e_addr, e_data, e_dac;

  always #2.5 clk = ~clk;

  esc_cmd_decoder u0 (.clk, .rst_n, .rx_valid, .rx_byte, .board_id,
    .cmd_level, .wr_en, .wr_dac, .wr_addr, .wr_data);

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_payload(byte unsigned b);
    m_q.push_back(b);
    if (!m_in_data && m_q.size() == 6) begin
      m_tgt  = {m_q[1], m_q[0]};
      m_addr = {m_q[3], m_q[2]};
      m_end  = {m_q[5], m_q[4]};
      m_q.delete();
      m_in_data = 1;
    end else if (m_in_data && m_q.size() == 2) begin
      e_data = {m_q[1], m_q[0]};
      m_q.delete();
      e_addr = m_addr;
      e_dac  = m_tgt % 16;
      e_wen  = ((m_tgt / 16) % 16 == int'(board_id)) && (e_dac < 3);
      if (m_addr == m_end) m_in_data = 0;
      m_addr = (m_addr + 1) % 65536;
    end
  endtask

  task automatic model_step(bit v, byte unsigned b);
    e_wen = 0;
    if (!v) return;
    if (m_esc) begin
      m_esc = 0;
      if (b == 8'hA5) model_payload(b);
      else if (b < 10) begin
        if (b / 2 == 0) begin
          m_lvl = '0;
          m_q.delete();
          m_in_data = 0;
        end
        m_lvl[b / 2] = (b % 2 == 0);
      end else begin
        m_q.delete();
        m_in_data = 0;
      end
    end else if (b == 8'hA5) m_esc = 1;
    else model_payload(b);
  endtask

  task automatic compare();
    check(cmd_level == m_lvl, "cmd_level", int'(cmd_level), int'(m_lvl));
    check(wr_en == e_wen, "wr_en", int'(wr_en), int'(e_wen));
    if (e_wen) begin
      check(int'(wr_addr) == e_addr, "wr_addr", int'(wr_addr), e_addr);
      check(int'(wr_data) == e_data, "wr_data", int'(wr_data), e_data);
      check(int'(wr_dac) == e_dac, "wr_dac", int'(wr_dac), e_dac);
    end
  endtask

  // drive at falling edge, compare one falling edge later
  task automatic step(bit v, byte unsigned b);
    rx_valid = v;
    rx_byte  = b;
    model_step(v, b);
    @(negedge clk);
    compare();
  endtask

  task automatic raw(byte unsigned b);  step(1, b); endtask
  task automatic idle();                step(0, 8'h00); endtask
  task automatic cmd(int idx, bit dis); raw(8'hA5); raw(8'(idx * 2 + int'(dis))); endtask
  task automatic pbyte(byte unsigned b);
    if (b == 8'hA5) raw(8'hA5);
    raw(b);
  endtask
  task automatic pword(int w); pbyte(8'(w % 256)); pbyte(8'(w / 256)); endtask
  task automatic header(int brd, int dac, int s, int e);
    pword(brd * 16 + dac); pword(s); pword(e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    board_id = 4'd6;
    rst_n = 0; rx_valid = 0; rx_byte = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    check(cmd_level == 0, "cmd_level in reset", int'(cmd_level), 0);
    check(wr_en == 0, "wr_en in reset", int'(wr_en), 0);
    rst_n = 1;
    idle(); idle();

    req = "R2";
    for (int i = 1; i < 5; i++) cmd(i, 0);
    cmd(2, 1);
    req = "R3";
    cmd(4, 0); idle(); cmd(3, 1); cmd(1, 1); cmd(1, 0);
    req = "R11";
    idle(); idle(); idle();

    req = "R6";
    header(6, 1, 16'h0010, 16'h0012);
    pword(16'h1234); idle(); pword(16'hBEEF); pword(16'h0042);
    header(6, 0, 16'hFFFF, 16'hFFFF);
    pword(16'h55AA);

    req = "R7";
    header(6, 2, 16'h00A5, 16'h00A6);
    pword(16'hA5A5); pword(16'h01A5);

    req = "R8";
    header(5, 0, 16'h0000, 16'h0001);
    pword(16'h1111); pword(16'h2222);
    header(6, 3, 16'h0000, 16'h0000);
    pword(16'h3333);
    header(6, 0, 16'h0020, 16'h0020);
    pword(16'h4444);

    req = "R10";
    header(6, 1, 16'h0100, 16'h0102);
    pword(16'h0A0B); cmd(1, 0); pbyte(8'h0C); cmd(3, 0); pbyte(8'h0D);
    pword(16'h0E0F);

    req = "R9";
    header(6, 0, 16'h0200, 16'h0203);
    pbyte(8'h99); raw(8'hA5); raw(8'h7E);
    header(6, 2, 16'h0300, 16'h0300);
    pword(16'h7777);
    raw(8'hA5); raw(8'h0A);
    header(6, 1, 16'h0301, 16'h0301);
    pword(16'h8888);

    req = "R4";
    header(6, 0, 16'h0400, 16'h0405);
    pword(16'h9999); pbyte(8'h12);
    cmd(0, 0);
    cmd(0, 1);
    header(6, 2, 16'h0500, 16'h0500);
    pword(16'hCAFE);
    cmd(4, 0); cmd(2, 0); cmd(0, 0);
    idle();

    req = "R5";
    header(6, 2, 16'h1000, 16'h1001);
    pword(16'h0001); pword(16'h0002);
    idle(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule